// File: doc/BRIEF.md
# Power-Good and Restart Sequencer

This block sits in the digital part of a hot-swap controller and owns the user control inputs and the power-good flag. Two active-low request inputs arrive from the board: a level-sensitive shutdown request and an edge-sensitive restart request. Each passes through a synchroniser and a glitch filter that accepts a new level only after it has been seen for a set number of consecutive clock ticks. While the filtered shutdown request is low, the external pass transistor is held off.

A falling edge of the filtered restart request starts a long forced-off interval that behaves like pulling the card out and plugging it back in. The gate is held off for a fixed number of ticks and then released with no further action from the user. Further restart edges during that interval are ignored. When a shutdown or a restart request is accepted, the block sends a one-cycle clear pulse to the fault latch of the retry controller. If the latched-fault output is wired back into the restart input, the result is continuous auto-retry with a long cooling pause after each group of retries.

Power-good is a latch, not a live comparison. It sets when the drain-low indication appears while the supply is inside its window and the gate is not inhibited. It clears when the supply leaves the window, when a current-limit timeout pulse arrives, or while the gate is inhibited.

Top module: `pwrgood_restart_seq`

## Requirements
- R1: A low level on `shutdown_n` that lasts at least FILT_TICKS consecutive synchronised samples sets `gate_inhibit` to 1 and holds it there while the low level lasts. A shorter low pulse leaves `gate_inhibit` at 0.
- R2: When `shutdown_n` returns high for FILT_TICKS consecutive samples, `gate_inhibit` returns to 0, provided no restart interval is running.
- R3: A filtered falling edge on `restart_n` (low for at least FILT_TICKS samples) holds `gate_inhibit` at 1 for exactly HOLD_TICKS clock cycles. After that the gate is released on its own.
- R4: A low pulse on `restart_n` shorter than FILT_TICKS samples starts no interval and produces no clear pulse.
- R5: A second filtered restart edge during a running interval is ignored. The interval keeps its original length and no extra clear pulse is produced.
- R6: `fault_clear` is a single-cycle pulse. It is issued once for each filtered falling edge of `shutdown_n` and once for each accepted restart edge.
- R7: `power_good` becomes 1 on the clock after `drain_low` is 1 while `supply_ok` is 1, `ilim_timeout` is 0 and the gate is not inhibited. It then stays 1 after `drain_low` drops.
- R8: `power_good` becomes 0 on the clock after `supply_ok` is 0 or `ilim_timeout` is 1. It stays 0 until the set condition of R7 occurs again.
- R9: `power_good` is 0 on every clock that follows a cycle with `gate_inhibit` at 1.
- R10: While `rst_n` is low, `gate_inhibit`, `power_good` and `fault_clear` are 0, and both filtered request levels read as high (inactive).
- R11: The restart interval is started only by a falling edge. A `restart_n` that stays low past the end of the interval does not start it again. The input must go high and fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown_n | input | 1 | Raw level-sensitive shutdown request, active low |
| restart_n | input | 1 | Raw edge-sensitive restart request, active low |
| drain_low | input | 1 | Drain voltage below the power-good threshold |
| supply_ok | input | 1 | Supply inside its allowed window |
| ilim_timeout | input | 1 | One-cycle pulse at a current-limit on-time expiry |
| gate_inhibit | output | 1 | 1 forces the pass transistor gate off |
| power_good | output | 1 | Latched power-good flag |
| fault_clear | output | 1 | One-cycle clear pulse to the retry fault latch |

## Verification
Request pulses just below and just above the filter length show whether the filter counts consecutive samples or only looks for any low sample. Three restart patterns are applied: a single clean pulse, a pulse followed by a second one in the middle of the interval, and a level held low well past the interval. Together these separate a correct edge trigger from a retrigger, an interval that gets extended, and a level trigger. Power-good is driven with drain-low pulses around timeout pulses and supply dips, which shows latch behaviour apart from a live comparison. A long random phase, checked every clock against a behavioural model, catches any wrong priority between set and clear.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic {PH_RUN = 1'b0, PH_HOLD = 1'b1} hold_phase_t;

  // bits needed to count 0 .. n-1
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/prs_deglitch.sv
module prs_deglitch #(
  parameter int TICKS  = 4,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_o,
  output logic fell_o
);
  localparam int CW = prs_pkg::cnt_width(TICKS);

  logic [STAGES-1:0] sync_q;
  logic [CW-1:0]     cnt_q;
  logic              seen;

  assign seen = sync_q[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= raw_in;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], raw_in};
    end
  endgenerate

  // accept a new level only after TICKS consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_o <= 1'b1;
      cnt_q   <= '0;
      fell_o  <= 1'b0;
    end else begin
      fell_o <= 1'b0;
      if (seen == level_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(TICKS - 1)) begin
        level_o <= seen;
        cnt_q   <= '0;
        fell_o  <= ~seen;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/prs_hold_timer.sv
module prs_hold_timer #(
  parameter int TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic accept_o,
  output logic active_o
);
  import prs_pkg::*;
  localparam int CW = cnt_width(TICKS);

  hold_phase_t   phase_q;
  logic [CW-1:0] cnt_q;

  assign accept_o = trig_i && (phase_q == PH_RUN);
  assign active_o = (phase_q == PH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
    end else if (accept_o) begin
      phase_q <= PH_HOLD;
      cnt_q   <= CW'(TICKS - 1);
    end else if (phase_q == PH_HOLD) begin
      if (cnt_q == '0) phase_q <= PH_RUN;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/prs_pg_latch.sv
module prs_pg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pg_o
);
  // clear wins over set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pg_o <= 1'b0;
    else if (clr_i) pg_o <= 1'b0;
    else if (set_i) pg_o <= 1'b1;
  end
endmodule

// File: rtl/pwrgood_restart_seq.sv
module pwrgood_restart_seq #(
  parameter int FILT_TICKS  = 500,
  parameter int HOLD_TICKS  = 500_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shutdown_n,
  input  logic restart_n,
  input  logic drain_low,
  input  logic supply_ok,
  input  logic ilim_timeout,
  output logic gate_inhibit,
  output logic power_good,
  output logic fault_clear
);
  logic shut_level, shut_fell;
  logic restart_level, restart_fell;
  logic hold_accept, hold_active;

  prs_deglitch #(.TICKS(FILT_TICKS), .STAGES(SYNC_STAGES)) shut_flt_i (
    .clk(clk), .rst_n(rst_n), .raw_in(shutdown_n),
    .level_o(shut_level), .fell_o(shut_fell)
  );

  prs_deglitch #(.TICKS(FILT_TICKS), .STAGES(SYNC_STAGES)) rst_flt_i (
    .clk(clk), .rst_n(rst_n), .raw_in(restart_n),
    .level_o(restart_level), .fell_o(restart_fell)
  );

  prs_hold_timer #(.TICKS(HOLD_TICKS)) hold_i (
    .clk(clk), .rst_n(rst_n), .trig_i(restart_fell),
    .accept_o(hold_accept), .active_o(hold_active)
  );

  assign gate_inhibit = ~shut_level | hold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_clear <= 1'b0;
    else        fault_clear <= shut_fell | hold_accept;
  end

  prs_pg_latch pg_i (
    .clk(clk), .rst_n(rst_n),
    .set_i(drain_low & supply_ok),
    .clr_i(~supply_ok | ilim_timeout | gate_inhibit),
    .pg_o(power_good)
  );
endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
  parameter int HOLD_TICKS = 40
) (
  input logic clk,
  input logic rst_n,
  input logic shut_level,
  input logic restart_level,
  input logic hold_active,
  input logic fault_clear,
  input logic gate_inhibit,
  input logic power_good,
  input logic drain_low,
  input logic supply_ok,
  input logic ilim_timeout
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_q <= 0;
    else if (hold_active) run_q <= run_q + 1;
    else                  run_q <= 0;
  end

  a_r1_shut_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_level |-> gate_inhibit);

  a_r3_hold_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> run_q < HOLD_TICKS);

  a_r5_hold_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> run_q == HOLD_TICKS);

  a_r6_clear_on_shut: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shut_level) |=> fault_clear);

  a_r6_clear_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> fault_clear);

  a_r7_pg_needs_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_good) |-> $past(drain_low && supply_ok));

  a_r8_pg_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok || ilim_timeout) |=> !power_good);

  a_r9_pg_off_inhibited: assert property (@(posedge clk) disable iff (!rst_n)
    gate_inhibit |=> !power_good);

  a_r11_start_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> !restart_level);
endmodule

bind pwrgood_restart_seq prs_checker #(.HOLD_TICKS(HOLD_TICKS)) chk_i (.*);

// File: tb/pwrgood_restart_seq_tb_top.sv
module pwrgood_restart_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 4;
  localparam int HOLD = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shutdown_n = 1'b1, restart_n = 1'b1;
  logic drain_low = 1'b0, supply_ok = 1'b0, ilim_timeout = 1'b0;
  logic gate_inhibit, power_good, fault_clear;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrgood_restart_seq #(.FILT_TICKS(FILT), .HOLD_TICKS(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .shutdown_n(shutdown_n), .restart_n(restart_n),
    .drain_low(drain_low), .supply_ok(supply_ok), .ilim_timeout(ilim_timeout),
    .gate_inhibit(gate_inhibit), .power_good(power_good), .fault_clear(fault_clear)
  );

  // behavioural reference model
  bit hs[$], hr[$];
  bit m_fs, m_fr, m_fs_fell, m_fr_fell, m_clr, m_pg;
  int m_hold;

  function automatic bit flt_step(ref bit h[$], input bit cur, output bit nv);
    bit all_diff = 1;
    for (int i = 2; i <= FILT + 1; i++) if (h[i] == cur) all_diff = 0;
    nv = all_diff ? !cur : cur;
    return all_diff && cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      hs = {}; hr = {};
      for (int i = 0; i < FILT + 2; i++) begin hs.push_back(1'b1); hr.push_back(1'b1); end
      m_fs = 1; m_fr = 1; m_fs_fell = 0; m_fr_fell = 0; m_clr = 0; m_pg = 0; m_hold = 0;
    end else begin
      bit inh_old, acc, nfs, nfr, fsf, frf;
      inh_old = !m_fs || (m_hold > 0);
      acc = m_fr_fell && (m_hold == 0);
      m_clr = m_fs_fell || acc;
      m_hold = acc ? HOLD : ((m_hold > 0) ? m_hold - 1 : 0);
      if (!supply_ok || ilim_timeout || inh_old) m_pg = 0;
      else if (drain_low) m_pg = 1;
      hs.push_front(shutdown_n); void'(hs.pop_back());
      hr.push_front(restart_n);  void'(hr.pop_back());
      fsf = flt_step(hs, m_fs, nfs);
      frf = flt_step(hr, m_fr, nfr);
      m_fs = nfs; m_fr = nfr; m_fs_fell = fsf; m_fr_fell = frf;
    end
  end

  // per-clock comparison and run/pulse bookkeeping
  int cur_run = 0, last_run = 0, clr_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit exp_inh;
      exp_inh = !m_fs || (m_hold > 0);
      checks += 3;
      if (gate_inhibit !== exp_inh) begin
        failures++;
        $display("FAIL R1 R2 R3 R5 R11 gate_inhibit got=%0b exp=%0b t=%0t", gate_inhibit, exp_inh, $time);
      end
      if (power_good !== m_pg) begin
        failures++;
        $display("FAIL R7 R8 R9 power_good got=%0b exp=%0b t=%0t", power_good, m_pg, $time);
      end
      if (fault_clear !== m_clr) begin
        failures++;
        $display("FAIL R4 R6 fault_clear got=%0b exp=%0b t=%0t", fault_clear, m_clr, $time);
      end
      if (gate_inhibit) cur_run++;
      else if (cur_run > 0) begin last_run = cur_run; cur_run = 0; end
      if (fault_clear) clr_cnt++;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0;
    step(3);
    check(gate_inhibit == 0 && power_good == 0 && fault_clear == 0, "R10 reset outputs",
          {gate_inhibit, power_good, fault_clear}, 0);
    rst_n = 1;
    step(5);
    check(gate_inhibit == 0, "R10 inactive after reset", gate_inhibit, 0);

    // power-good latch
    supply_ok = 1; drain_low = 1; step(2);
    check(power_good == 1, "R7 set", power_good, 1);
    drain_low = 0; step(3);
    check(power_good == 1, "R7 latched", power_good, 1);
    ilim_timeout = 1; step(1); ilim_timeout = 0; step(1);
    check(power_good == 0, "R8 timeout clears", power_good, 0);
    step(3);
    check(power_good == 0, "R8 stays clear", power_good, 0);
    drain_low = 1; step(1); drain_low = 0; step(1);
    check(power_good == 1, "R7 reset by drain", power_good, 1);
    supply_ok = 0; step(2);
    check(power_good == 0, "R8 supply clears", power_good, 0);
    supply_ok = 1; drain_low = 1; step(2);

    // short shutdown glitch
    shutdown_n = 0; step(FILT - 1); shutdown_n = 1;
    for (int i = 0; i < 12; i++) begin
      step(1);
      check(gate_inhibit == 0, "R1 short shutdown ignored", gate_inhibit, 0);
    end

    // real shutdown
    c0 = clr_cnt;
    shutdown_n = 0; step(FILT + 4);
    check(gate_inhibit == 1, "R1 shutdown inhibits", gate_inhibit, 1);
    check(power_good == 0, "R9 pg low inhibited", power_good, 0);
    step(10);
    check(clr_cnt - c0 == 1, "R6 one clear on shutdown", clr_cnt - c0, 1);
    shutdown_n = 1; step(FILT + 4);
    check(gate_inhibit == 0, "R2 release", gate_inhibit, 0);
    check(power_good == 1, "R7 pg back after release", power_good, 1);

    // short restart glitch
    c0 = clr_cnt;
    restart_n = 0; step(2); restart_n = 1;
    for (int i = 0; i < 20; i++) begin
      step(1);
      check(gate_inhibit == 0, "R4 short restart ignored", gate_inhibit, 0);
    end
    check(clr_cnt == c0, "R4 no clear", clr_cnt - c0, 0);

    // clean restart
    c0 = clr_cnt;
    restart_n = 0; step(6); restart_n = 1; step(HOLD + 20);
    check(last_run == HOLD, "R3 interval length", last_run, HOLD);
    check(gate_inhibit == 0, "R3 auto release", gate_inhibit, 0);
    check(clr_cnt - c0 == 1, "R6 one clear on restart", clr_cnt - c0, 1);

    // second edge during interval
    c0 = clr_cnt;
    restart_n = 0; step(6); restart_n = 1; step(15);
    restart_n = 0; step(6); restart_n = 1; step(HOLD + 20);
    check(last_run == HOLD, "R5 interval not extended", last_run, HOLD);
    check(clr_cnt - c0 == 1, "R5 no extra clear", clr_cnt - c0, 1);

    // restart held low
    c0 = clr_cnt;
    restart_n = 0; step(HOLD + 60);
    check(last_run == HOLD, "R11 held low single interval", last_run, HOLD);
    check(gate_inhibit == 0, "R11 no retrigger while low", gate_inhibit, 0);
    check(clr_cnt - c0 == 1, "R11 one clear", clr_cnt - c0, 1);
    restart_n = 1; step(20);
    check(gate_inhibit == 0, "R11 rising edge no effect", gate_inhibit, 0);

    // random phase, checked against the model every clock
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(29) == 0) shutdown_n = ~shutdown_n;
      if ($urandom_range(24) == 0) restart_n = ~restart_n;
      if ($urandom_range(49) == 0) supply_ok = ~supply_ok;
      drain_low = ($urandom_range(7) == 0);
      ilim_timeout = ($urandom_range(39) == 0);
    end
    step(2);
    finish_run();
  end
endmodule